// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Control

This block is the hazard controller of a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Data read from memory only exists at the end of the memory stage. An instruction that needs a loaded value in the very next slot therefore cannot be served by bypassing. The block detects that case in hardware. It freezes fetch and decode for one cycle and sends a no-op into execute, so a stale register value is never consumed. ALU results need no waiting. They are bypassed from the pipeline registers, so dependent arithmetic runs back to back.

The block keeps its own shadow copy of the register tags that sit in the execute, memory and writeback slots. From the decode-stage register fields it produces the stall controls for the current cycle. From the shadow tags it produces, for each source operand of the instruction now in execute, a select for the operand multiplexer. The register file, the ALU, the memory and the datapath registers stay outside.

Top module: `ldu_interlock`

## Requirements
- R1: When the execute slot holds a load whose destination is not register 0, and that destination equals a used source of the decode slot, `stall_fetch`, `stall_decode` and `bubble_exec` are all 1 in that same cycle.
- R2: A dependence on an ALU result never stalls, whatever its distance. A load followed by one independent instruction and then its consumer causes no stall.
- R3: Each adjacent load-use pair costs exactly one stall cycle. The cycle after a stall never stalls, because the no-op now in execute writes nothing.
- R4: A source whose `id_src_used` bit is 0 never causes a stall. Once in execute, it always gets select 00.
- R5: Register 0 reads as zero. With `ZERO_REG`=1 it never causes a stall or a bypass, even when an older instruction names it as destination.
- R6: The select for source k is `fwd_sel[2k+1:2k]`. 00 reads the register file, 01 takes the result one slot ahead (the execute-to-memory register), and 10 takes the result two slots ahead (the memory-to-writeback register). 11 never occurs. Source 0 is the base or first operand, and source 1 is the second ALU operand.
- R7: When both older slots write the register a source reads, the younger one wins, so the select is 01.
- R8: After a load-use stall, the consumer receives the loaded value through select 10. Every instruction ends with the same result that strict sequential execution gives.
- R9: During reset and on the first cycle after it, no stall and no bypass is signalled, whatever the decode inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the shadow tags |
| id_src_idx | input | NSRC*AW (10) | Source register numbers of the decode instruction, source k at [AW*k +: AW] |
| id_src_used | input | NSRC (2) | Bit k set when source k is really read |
| id_dst | input | AW (5) | Destination register of the decode instruction |
| id_dst_wen | input | 1 | Decode instruction writes `id_dst` |
| id_is_load | input | 1 | Decode instruction is a memory load |
| stall_fetch | output | 1 | Hold the fetch program counter |
| stall_decode | output | 1 | Hold the fetch-to-decode register |
| bubble_exec | output | 1 | Load a no-op into the decode-to-execute register |
| fwd_sel | output | 2*NSRC (4) | Operand selects for the instruction in execute |

## Verification
The bench targets the stall count and the bypass choice in each corner of the hazard rule. A back-to-back load and consumer must cost exactly one cycle. A design that did not stall would pass the stale register value, and one that stalled twice would lose a cycle. A load with one independent instruction before its consumer, an ALU chain, and a second load whose unused field names the loaded register must all run with no stall. A design comparing unused fields, or stalling on ALU producers, would show extra bubbles. Register 0 written just before being read, and a register written by both older slots, expose a bypass of a nonzero value into register 0 and a wrong priority that picks the older result. A pseudo-random stream then mixes all of these together.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      FWD_RF    = 2'b00,
      FWD_EXMEM = 2'b01,
      FWD_MEMWB = 2'b10
   } fwd_sel_e;

endpackage

// File: rtl/ldu_tag_pipe.sv
module ldu_tag_pipe #(
   parameter int NSRC = 2,
   parameter int AW   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_ex,
   input  logic [NSRC*AW-1:0] id_src_idx,
   input  logic [NSRC-1:0]    id_src_used,
   input  logic [AW-1:0]      id_dst,
   input  logic               id_dst_wen,
   input  logic               id_is_load,
   output logic [NSRC*AW-1:0] ex_src_idx,
   output logic [NSRC-1:0]    ex_src_used,
   output logic [AW-1:0]      ex_dst,
   output logic               ex_wen,
   output logic               ex_load,
   output logic [AW-1:0]      mem_dst,
   output logic               mem_wen,
   output logic [AW-1:0]      wb_dst,
   output logic               wb_wen
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_src_idx  <= '0;
         ex_src_used <= '0;
         ex_dst      <= '0;
         ex_wen      <= 1'b0;
         ex_load     <= 1'b0;
         mem_dst     <= '0;
         mem_wen     <= 1'b0;
         wb_dst      <= '0;
         wb_wen      <= 1'b0;
      end else begin
         if (flush_ex) begin
            ex_src_idx  <= '0;
            ex_src_used <= '0;
            ex_dst      <= '0;
            ex_wen      <= 1'b0;
            ex_load     <= 1'b0;
         end else begin
            ex_src_idx  <= id_src_idx;
            ex_src_used <= id_src_used;
            ex_dst      <= id_dst;
            ex_wen      <= id_dst_wen;
            ex_load     <= id_is_load;
         end
         mem_dst <= ex_dst;
         mem_wen <= ex_wen;
         wb_dst  <= mem_dst;
         wb_wen  <= mem_wen;
      end
   end

endmodule

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
   parameter int NSRC     = 2,
   parameter int AW       = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic               ex_load,
   input  logic               ex_wen,
   input  logic [AW-1:0]      ex_dst,
   input  logic [NSRC*AW-1:0] id_src_idx,
   input  logic [NSRC-1:0]    id_src_used,
   output logic               hazard
);

   logic            dst_real;
   logic [NSRC-1:0] hit;

   generate
      if (ZERO_REG) begin : g_zero_hard
         assign dst_real = |ex_dst;
      end else begin : g_zero_soft
         assign dst_real = 1'b1;
      end

      for (genvar k = 0; k < NSRC; k++) begin : g_src
         assign hit[k] = id_src_used[k] && (id_src_idx[k*AW +: AW] == ex_dst);
      end
   endgenerate

   assign hazard = ex_load && ex_wen && dst_real && (|hit);

endmodule

// File: rtl/ldu_fwd_select.sv
module ldu_fwd_select #(
   parameter int AW       = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic              [AW-1:0] src,
   input  logic                       used,
   input  logic              [AW-1:0] mem_dst,
   input  logic                       mem_wen,
   input  logic              [AW-1:0] wb_dst,
   input  logic                       wb_wen,
   output ldu_pkg::fwd_sel_e          sel
);

   logic src_real;

   generate
      if (ZERO_REG) begin : g_zero_hard
         assign src_real = |src;
      end else begin : g_zero_soft
         assign src_real = 1'b1;
      end
   endgenerate

   always_comb begin
      sel = ldu_pkg::FWD_RF;
      if (used && src_real) begin
         if (mem_wen && (mem_dst == src)) begin
            sel = ldu_pkg::FWD_EXMEM;
         end else if (wb_wen && (wb_dst == src)) begin
            sel = ldu_pkg::FWD_MEMWB;
         end
      end
   end

endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock #(
   parameter int NREG     = 32,
   parameter int NSRC     = 2,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC*AW-1:0] id_src_idx,
   input  logic [NSRC-1:0]    id_src_used,
   input  logic [AW-1:0]      id_dst,
   input  logic               id_dst_wen,
   input  logic               id_is_load,
   output logic               stall_fetch,
   output logic               stall_decode,
   output logic               bubble_exec,
   output logic [2*NSRC-1:0]  fwd_sel
);

   generate
      if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
         $error("ldu_interlock: NREG must be a power of two of at least 2");
      end
      if (NSRC < 1 || NSRC > 4) begin : g_bad_nsrc
         $error("ldu_interlock: NSRC must lie between 1 and 4");
      end
   endgenerate

   logic [NSRC*AW-1:0] ex_src_idx;
   logic [NSRC-1:0]    ex_src_used;
   logic [AW-1:0]      ex_dst;
   logic               ex_wen;
   logic               ex_load;
   logic [AW-1:0]      mem_dst;
   logic               mem_wen;
   logic [AW-1:0]      wb_dst;
   logic               wb_wen;
   logic               hazard;

   ldu_tag_pipe #(.NSRC(NSRC), .AW(AW)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_ex    (hazard),
      .id_src_idx  (id_src_idx),
      .id_src_used (id_src_used),
      .id_dst      (id_dst),
      .id_dst_wen  (id_dst_wen),
      .id_is_load  (id_is_load),
      .ex_src_idx  (ex_src_idx),
      .ex_src_used (ex_src_used),
      .ex_dst      (ex_dst),
      .ex_wen      (ex_wen),
      .ex_load     (ex_load),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .wb_dst      (wb_dst),
      .wb_wen      (wb_wen)
   );

   ldu_hazard_detect #(.NSRC(NSRC), .AW(AW), .ZERO_REG(ZERO_REG)) u_detect (
      .ex_load     (ex_load),
      .ex_wen      (ex_wen),
      .ex_dst      (ex_dst),
      .id_src_idx  (id_src_idx),
      .id_src_used (id_src_used),
      .hazard      (hazard)
   );

   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_byp
         ldu_pkg::fwd_sel_e sel_k;
         ldu_fwd_select #(.AW(AW), .ZERO_REG(ZERO_REG)) u_sel (
            .src     (ex_src_idx[k*AW +: AW]),
            .used    (ex_src_used[k]),
            .mem_dst (mem_dst),
            .mem_wen (mem_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (sel_k)
         );
         assign fwd_sel[2*k +: 2] = sel_k;
      end
   endgenerate

   assign stall_fetch  = hazard;
   assign stall_decode = hazard;
   assign bubble_exec  = hazard;

endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
   parameter int NSRC     = 2,
   parameter int AW       = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bubble_exec,
   input logic [2*NSRC-1:0]  fwd_sel,
   input logic [NSRC*AW-1:0] ex_src_idx,
   input logic [NSRC-1:0]    ex_src_used,
   input logic [AW-1:0]      ex_dst,
   input logic               ex_wen,
   input logic               ex_load
);

   // R1: a stall is only ever caused by a writing load in execute
   p_stall_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_exec |-> (ex_load && ex_wen && (!ZERO_REG || ex_dst != '0)));

   // R3: one stall cycle per pair, the no-op then sits in execute
   p_single_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_exec |=> !bubble_exec);

   p_bubble_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_exec |=> (!ex_wen && !ex_load));

   // R9: nothing signalled on the first cycle out of reset
   p_clean_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fwd_sel == '0 && !bubble_exec));

   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_src
         // R6: code 11 is never produced
         p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel[2*k +: 2] != 2'b11);
         // R4: unused sources read the register file
         p_unused_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !ex_src_used[k] |-> fwd_sel[2*k +: 2] == 2'b00);
         if (ZERO_REG) begin : g_zero
            // R5: register 0 is never bypassed
            p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (ex_src_idx[k*AW +: AW] == '0) |-> fwd_sel[2*k +: 2] == 2'b00);
         end
      end
   endgenerate

endmodule

bind ldu_interlock ldu_interlock_chk #(.NSRC(NSRC), .AW(AW), .ZERO_REG(ZERO_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bubble_exec (bubble_exec),
   .fwd_sel     (fwd_sel),
   .ex_src_idx  (ex_src_idx),
   .ex_src_used (ex_src_used),
   .ex_dst      (ex_dst),
   .ex_wen      (ex_wen),
   .ex_load     (ex_load)
);

// File: tb/ldu_interlock_tb.sv
`timescale 1ns/1ps
module ldu_interlock_tb;

   localparam int NSRC = 2;
   localparam int AW   = 5;

   typedef struct {
      bit          v;
      bit          ld;
      logic [4:0]  rd;
      logic [4:0]  rs;
      logic [4:0]  rt;
      logic [31:0] val;
      string       tag;
   } slot_t;

   typedef struct {
      logic [4:0]  rd;
      logic [31:0] val;
      string       tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NSRC*AW-1:0] id_src_idx = '0;
   logic [NSRC-1:0]    id_src_used = '0;
   logic [AW-1:0]      id_dst = '0;
   logic               id_dst_wen = 1'b0;
   logic               id_is_load = 1'b0;
   logic               stall_fetch, stall_decode, bubble_exec;
   logic [2*NSRC-1:0]  fwd_sel;

   ldu_interlock u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .id_src_idx   (id_src_idx),
      .id_src_used  (id_src_used),
      .id_dst       (id_dst),
      .id_dst_wen   (id_dst_wen),
      .id_is_load   (id_is_load),
      .stall_fetch  (stall_fetch),
      .stall_decode (stall_decode),
      .bubble_exec  (bubble_exec),
      .fwd_sel      (fwd_sel)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int cyc = 0;

   slot_t prog [0:127];
   int    nprog = 0;
   logic [31:0] grf [0:31];
   logic [31:0] rf  [0:31];
   exp_t  sbq [$];
   slot_t dec, ex, mem, wb, empty_slot;
   int    pc, seg_end;

   function automatic logic [31:0] mem_f(logic [31:0] a);
      return (a ^ 32'h00C0FFEE) + 32'd17;
   endfunction

   // driver: append to program and push the expected result
   task automatic emit(bit ld, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, string tag);
      slot_t s;
      exp_t  e;
      logic [31:0] a, b;
      a = grf[rs];
      b = grf[rt];
      s.v = 1'b1; s.ld = ld; s.rd = rd; s.rs = rs; s.rt = rt; s.val = '0; s.tag = tag;
      prog[nprog] = s;
      nprog++;
      e.rd = rd;
      e.val = ld ? mem_f(a) : a + b + 32'd1;
      e.tag = tag;
      if (rd != 0) grf[rd] = e.val;
      sbq.push_back(e);
   endtask

   task automatic drive(slot_t s);
      id_src_idx  = {s.rt, s.rs};
      id_src_used = {s.v && !s.ld, s.v};
      id_dst      = s.rd;
      id_dst_wen  = s.v;
      id_is_load  = s.v && s.ld;
   endtask

   function automatic logic [31:0] pick(logic [1:0] sel, logic [4:0] r, slot_t m, slot_t w);
      if (sel == 2'b01) return m.val;
      if (sel == 2'b10) return w.val;
      return rf[r];
   endfunction

   // monitor: pop and compare each instruction as it leaves writeback
   task automatic monitor(slot_t w);
      exp_t e;
      n_chk++;
      if (sbq.size() == 0) begin
         n_fail++;
         $display("FAIL %s: retired r%0d=%h, expected no retirement", w.tag, w.rd, w.val);
      end else begin
         e = sbq.pop_front();
         if (e.rd !== w.rd || e.val !== w.val) begin
            n_fail++;
            $display("FAIL %s R8: result r%0d=%h, expected r%0d=%h", e.tag, w.rd, w.val, e.rd, e.val);
         end
      end
      if (w.rd != 0) rf[w.rd] = w.val;
   endtask

   task automatic step(output bit b);
      slot_t nm, nw;
      logic [31:0] a, bb;
      logic [1:0] sa, sb;
      @(negedge clk);
      b  = bubble_exec;
      sa = fwd_sel[1:0];
      sb = fwd_sel[3:2];
      n_chk++;
      if (sa == 2'b11 || sb == 2'b11) begin
         n_fail++;
         $display("FAIL R6: select %b/%b, expected no code 11", sa, sb);
      end
      if (b) begin
         n_chk++;
         if (stall_fetch !== 1'b1 || stall_decode !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: holds %b%b during bubble, expected 11", stall_fetch, stall_decode);
         end
      end
      nm = ex;
      if (ex.v) begin
         a  = pick(sa, ex.rs, mem, wb);
         bb = pick(sb, ex.rt, mem, wb);
         nm.val = ex.ld ? a : a + bb + 32'd1;
      end
      nw = mem;
      if (mem.v && mem.ld) nw.val = mem_f(mem.val);
      if (wb.v) monitor(wb);
      wb  = nw;
      mem = nm;
      ex  = b ? empty_slot : dec;
      if (!b) begin
         pc++;
         dec = (pc < seg_end) ? prog[pc] : empty_slot;
      end
      @(posedge clk);
      #1;
      drive(dec);
   endtask

   function automatic int exp_bubbles(int s, int e);
      int cnt = 0;
      for (int i = s; i < e - 1; i++) begin
         if (prog[i].ld && prog[i].rd != 0 &&
             (prog[i+1].rs == prog[i].rd || (!prog[i+1].ld && prog[i+1].rt == prog[i].rd)))
            cnt++;
      end
      return cnt;
   endfunction

   int seg_start = 0;

   task automatic run_seg(string req);
      int  nb = 0;
      int  want;
      bit  b;
      want = exp_bubbles(seg_start, nprog);
      pc = seg_start;
      seg_end = nprog;
      dec = prog[pc];
      drive(dec);
      while (pc < seg_end || ex.v || mem.v || wb.v) begin
         step(b);
         if (b) nb++;
      end
      n_chk++;
      if (nb != want) begin
         n_fail++;
         $display("FAIL %s: stall cycles %0d, expected %0d", req, nb, want);
      end
      seg_start = nprog;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         n_fail++;
         $display("FAIL R3: run still busy after %0d cycles, expected under 20000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rng;
      logic [4:0]  last_rd, r_d, r_s, r_t;
      bit          is_ld;
      empty_slot = '{v: 1'b0, ld: 1'b0, rd: '0, rs: '0, rt: '0, val: '0, tag: ""};
      dec = empty_slot; ex = empty_slot; mem = empty_slot; wb = empty_slot;
      for (int i = 0; i < 32; i++) begin
         grf[i] = (i == 0) ? 32'd0 : i * 32'h111 + 32'd3;
         rf[i]  = grf[i];
      end

      // R9: a would-be hazard on the inputs during reset must be ignored
      id_src_idx = {5'd5, 5'd5}; id_src_used = 2'b11; id_dst = 5'd5;
      id_dst_wen = 1'b1; id_is_load = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (bubble_exec !== 1'b0 || stall_fetch !== 1'b0 || stall_decode !== 1'b0 || fwd_sel !== '0) begin
         n_fail++;
         $display("FAIL R9: in reset stall %b%b%b sel %b, expected 000 sel 0000",
                  stall_fetch, stall_decode, bubble_exec, fwd_sel);
      end
      drive(empty_slot);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (bubble_exec !== 1'b0 || fwd_sel !== '0) begin
         n_fail++;
         $display("FAIL R9: after reset bubble %b sel %b, expected 0 and 0000", bubble_exec, fwd_sel);
      end
      @(posedge clk); #1;

      // R1: back-to-back load and consumer, one bubble
      emit(1, 5'd3, 5'd1, 5'd0, "R1");
      emit(0, 5'd4, 5'd3, 5'd2, "R1");
      run_seg("R1");

      // R2: one independent instruction in between, then an ALU chain
      emit(1, 5'd5, 5'd1, 5'd0, "R2");
      emit(0, 5'd6, 5'd2, 5'd2, "R2");
      emit(0, 5'd7, 5'd5, 5'd6, "R2");
      emit(0, 5'd8, 5'd7, 5'd7, "R2");
      emit(0, 5'd9, 5'd8, 5'd1, "R2");
      run_seg("R2");

      // R4: second load's unused field names the loaded register
      emit(1, 5'd10, 5'd2, 5'd0, "R4");
      emit(1, 5'd11, 5'd1, 5'd10, "R4");
      run_seg("R4");

      // R5: register 0 as load target and ALU target, then read
      emit(1, 5'd0, 5'd1, 5'd0, "R5");
      emit(0, 5'd13, 5'd0, 5'd0, "R5");
      emit(0, 5'd0, 5'd1, 5'd2, "R5");
      emit(0, 5'd14, 5'd0, 5'd1, "R5");
      run_seg("R5");

      // R7: both older slots write the same register
      emit(0, 5'd15, 5'd1, 5'd1, "R7");
      emit(0, 5'd15, 5'd15, 5'd2, "R7");
      emit(0, 5'd16, 5'd15, 5'd15, "R7");
      run_seg("R7");

      // R3: consumer on second source, then load feeding a load address
      emit(1, 5'd17, 5'd1, 5'd0, "R3");
      emit(0, 5'd18, 5'd2, 5'd17, "R3");
      emit(1, 5'd19, 5'd18, 5'd0, "R3");
      emit(1, 5'd20, 5'd19, 5'd0, "R3");
      run_seg("R3");

      // R8: mixed pseudo-random stream
      rng = 32'h1234_5678;
      last_rd = 5'd1;
      for (int i = 0; i < 48; i++) begin
         rng = rng * 32'd1103515245 + 32'd12345;
         is_ld = rng[20];
         r_d = rng[27:23];
         r_s = rng[17] ? last_rd : rng[14:10];
         r_t = rng[18] ? last_rd : rng[9:5];
         emit(is_ld, r_d, r_s, r_t, "R8");
         last_rd = r_d;
      end
      run_seg("R8");

      n_chk++;
      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL R8: %0d results never retired, expected 0", sbq.size());
      end
      summary();
      $finish;
   end

endmodule